// File: doc/BRIEF.md
# SIMD Reconvergence Stack Controller

This block tracks divergent control flow for one warp of `LANES` lanes. Reconvergence happens at the immediate post-dominator. It holds a stack of entries. Each entry carries a resume PC, a reconvergence PC (absent on the bottom entry) and a lane mask. The top entry always names the PC and the mask that the warp issues with next. The block does not fetch instructions, execute them or compute post-dominators: the reconvergence PC comes in with every branch.

A kernel starts with `launch`, which leaves one bottom entry at `start_pc` with every lane active. For each issued instruction the pipeline reports either a resolved branch or a plain step to the next PC. When a branch splits the active lanes, the top entry is parked at the reconvergence PC. Two entries are then pushed, one for the not-taken lanes and one above it for the taken lanes. The taken path runs first. An entry whose resume PC reaches its own reconvergence PC is popped in a bubble cycle, and the lanes below carry on with their merged mask. `kernel_exit` drops every entry.

The branch channel is valid/ready. `br_ready` equals `valid_pc`, so a branch is held off during a pop bubble and while the stack is empty. A branch offered with `br_ready` low is not consumed and has no effect. `step_valid` is plain control with no ready of its own. It is acted on only in cycles where `valid_pc` is high and no branch is offered.

Top module: `simt_reconv_stack`

## Requirements
- R1: After reset the stack is empty: `stack_empty`=1, `valid_pc`=0, `br_ready`=0, `overflow`=0, `active_mask`=0.
- R2: `launch` (without `kernel_exit`) leaves one entry. From the next cycle `valid_pc`=1, `issue_pc`=`start_pc`, all mask bits are 1, and `overflow` clears.
- R3: If a branch splits the lanes and fewer than two free entries remain, `overflow` goes to 1 and the issued PC, mask and stack stay unchanged. `overflow` stays set until `launch` or `kernel_exit`.
- R4: A uniform branch pushes nothing. If every active lane is taken (`br_taken & active_mask == active_mask`), the top resumes at `br_target`. If no active lane is taken, it resumes at `br_fallthru`. The mask is unchanged in both cases.
- R5: A splitting branch sets the top entry's resume PC to `br_reconv`. It then pushes the not-taken lanes at `br_fallthru` and, on top of them, the taken lanes at `br_target`. Both new entries carry `br_reconv`. The next issue is `br_target` with mask `br_taken & active_mask`.
- R6: An accepted step sets the top entry's resume PC to `step_pc`. The mask is unchanged.
- R7: While a non-bottom top entry's resume PC equals its reconvergence PC, `valid_pc` is 0 for one cycle and the entry pops. The entry below then issues with its own mask.
- R8: The bottom entry never pops, whatever PC it reaches.
- R9: `kernel_exit` empties the stack and clears `overflow` from the next cycle. It takes priority over `launch`, branches and steps.
- R10: A branch or step offered while `valid_pc` is 0 has no effect.
- R11: When a branch and a step are offered together, only the branch is applied.
- R12: Mask bit i is lane i. For four lanes with A=0, B=1, C=2, D=3, E=4, G=6, the issue order is A/1111, B/1111, C/1001, D/0110, E/1111, G/1111. The B branch takes lanes 1001 to C, falls through to D and reconverges at E.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kernel_exit | input | 1 | Drop all entries |
| launch | input | 1 | Start a kernel at `start_pc` with a full mask |
| start_pc | input | PC_W | Kernel entry PC |
| br_valid | input | 1 | Resolved branch offered |
| br_ready | output | 1 | Branch accepted this cycle when high |
| br_taken | input | LANES | Per-lane taken outcome |
| br_target | input | PC_W | Taken target PC |
| br_fallthru | input | PC_W | Not-taken PC |
| br_reconv | input | PC_W | Immediate post-dominator PC of the branch |
| step_valid | input | 1 | Non-branch instruction finished |
| step_pc | input | PC_W | PC after that instruction |
| valid_pc | output | 1 | `issue_pc`/`active_mask` may issue |
| issue_pc | output | PC_W | Common PC of the warp |
| active_mask | output | LANES | Lanes active at `issue_pc` |
| stack_empty | output | 1 | No entries held |
| overflow | output | 1 | A split was refused for lack of room |

## Verification
Directed patterns cover four cases:
- A uniform all-taken branch, which tells R4 apart from a push.
- The 1001/0110 split from R12, which shows the taken path is ordered first and that the merge restores the full mask.
- Steps that land on the reconvergence PC, which expose the pop bubble and show that the bottom entry survives.
- Nested splits at depth 4, which force the overflow path.

Random traffic then mixes several kinds of stimulus:
- random taken masks, which give uniform and split outcomes in proportion;
- steps biased toward the live reconvergence PC, so that deep pops occur;
- branches offered during bubbles;
- simultaneous branch and step;
- launch and exit collisions.

Every output is compared each cycle against a reference stack held in bench functions.

// File: rtl/simt_stack_pkg.sv
package simt_stack_pkg;
  typedef enum logic [1:0] {
    BR_ALL_NT = 2'd0,
    BR_ALL_T  = 2'd1,
    BR_SPLIT  = 2'd2
  } br_kind_e;
endpackage

// File: rtl/simt_branch_classify.sv
module simt_branch_classify
  import simt_stack_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0] active,
  input  logic [LANES-1:0] taken,
  output br_kind_e         kind,
  output logic [LANES-1:0] t_mask,
  output logic [LANES-1:0] n_mask
);
  always_comb begin
    t_mask = active & taken;
    n_mask = active & ~taken;
    if (t_mask == '0)      kind = BR_ALL_NT;
    else if (n_mask == '0) kind = BR_ALL_T;
    else                   kind = BR_SPLIT;
  end
endmodule

// File: rtl/simt_stack_store.sv
module simt_stack_store #(
  parameter int LANES = 4,
  parameter int PC_W  = 8,
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [PC_W-1:0]  load_pc,
  input  logic             pop,
  input  logic             set_next,
  input  logic [PC_W-1:0]  next_val,
  input  logic             push2,
  input  logic [PC_W-1:0]  push_rc,
  input  logic [PC_W-1:0]  lo_pc,
  input  logic [LANES-1:0] lo_mask,
  input  logic [PC_W-1:0]  hi_pc,
  input  logic [LANES-1:0] hi_mask,
  output logic [CNT_W-1:0] cnt,
  output logic             top_has_rc,
  output logic [PC_W-1:0]  top_rc,
  output logic [PC_W-1:0]  top_next,
  output logic [LANES-1:0] top_mask
);
  logic             has_rc [DEPTH];
  logic [PC_W-1:0]  rc_pc  [DEPTH];
  logic [PC_W-1:0]  nx_pc  [DEPTH];
  logic [LANES-1:0] mask   [DEPTH];

  logic [IDX_W-1:0] top_idx, lo_idx, hi_idx;

  assign top_idx = IDX_W'(cnt - CNT_W'(1));
  assign lo_idx  = IDX_W'(cnt);
  assign hi_idx  = IDX_W'(cnt + CNT_W'(1));

  assign top_has_rc = has_rc[top_idx];
  assign top_rc     = rc_pc[top_idx];
  assign top_next   = nx_pc[top_idx];
  assign top_mask   = mask[top_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (load) begin
      cnt       <= CNT_W'(1);
      has_rc[0] <= 1'b0;
      rc_pc[0]  <= '0;
      nx_pc[0]  <= load_pc;
      mask[0]   <= '1;
    end else if (pop) begin
      cnt <= cnt - CNT_W'(1);
    end else begin
      if (set_next) nx_pc[top_idx] <= next_val;
      if (push2) begin
        has_rc[lo_idx] <= 1'b1;
        rc_pc[lo_idx]  <= push_rc;
        nx_pc[lo_idx]  <= lo_pc;
        mask[lo_idx]   <= lo_mask;
        has_rc[hi_idx] <= 1'b1;
        rc_pc[hi_idx]  <= push_rc;
        nx_pc[hi_idx]  <= hi_pc;
        mask[hi_idx]   <= hi_mask;
        cnt            <= cnt + CNT_W'(2);
      end
    end
  end
endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
  import simt_stack_pkg::*;
#(
  parameter int LANES = 4,
  parameter int PC_W  = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kernel_exit,
  input  logic             launch,
  input  logic [PC_W-1:0]  start_pc,
  input  logic             br_valid,
  output logic             br_ready,
  input  logic [LANES-1:0] br_taken,
  input  logic [PC_W-1:0]  br_target,
  input  logic [PC_W-1:0]  br_fallthru,
  input  logic [PC_W-1:0]  br_reconv,
  input  logic             step_valid,
  input  logic [PC_W-1:0]  step_pc,
  output logic             valid_pc,
  output logic [PC_W-1:0]  issue_pc,
  output logic [LANES-1:0] active_mask,
  output logic             stack_empty,
  output logic             overflow
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FIT_MAX = CNT_W'(DEPTH - 2);

  logic [CNT_W-1:0] cnt;
  logic             top_has_rc;
  logic [PC_W-1:0]  top_rc, top_next;
  logic [LANES-1:0] top_mask, t_mask, n_mask;
  br_kind_e         kind;

  logic pend_pop, br_fire, st_fire, fits, quiet;
  logic set_next, push2, pop;
  logic [PC_W-1:0] next_val;

  assign stack_empty = (cnt == '0);
  assign pend_pop    = !stack_empty && top_has_rc && (top_next == top_rc);
  assign valid_pc    = !stack_empty && !pend_pop;
  assign br_ready    = valid_pc;
  assign issue_pc    = stack_empty ? '0 : top_next;
  assign active_mask = stack_empty ? '0 : top_mask;

  assign quiet   = !kernel_exit && !launch;
  assign br_fire = quiet && br_valid && valid_pc;
  assign st_fire = quiet && step_valid && valid_pc && !br_valid;
  assign fits    = (cnt <= FIT_MAX);
  assign pop     = quiet && pend_pop;
  assign push2   = br_fire && (kind == BR_SPLIT) && fits;
  assign set_next = st_fire || (br_fire && ((kind != BR_SPLIT) || fits));

  always_comb begin
    if (st_fire)               next_val = step_pc;
    else if (kind == BR_ALL_T)  next_val = br_target;
    else if (kind == BR_ALL_NT) next_val = br_fallthru;
    else                        next_val = br_reconv;
  end

  simt_branch_classify #(.LANES(LANES)) u_classify (
    .active (top_mask),
    .taken  (br_taken),
    .kind   (kind),
    .t_mask (t_mask),
    .n_mask (n_mask)
  );

  simt_stack_store #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (kernel_exit),
    .load       (!kernel_exit && launch),
    .load_pc    (start_pc),
    .pop        (pop),
    .set_next   (set_next),
    .next_val   (next_val),
    .push2      (push2),
    .push_rc    (br_reconv),
    .lo_pc      (br_fallthru),
    .lo_mask    (n_mask),
    .hi_pc      (br_target),
    .hi_mask    (t_mask),
    .cnt        (cnt),
    .top_has_rc (top_has_rc),
    .top_rc     (top_rc),
    .top_next   (top_next),
    .top_mask   (top_mask)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   overflow <= 1'b0;
    else if (kernel_exit || launch)               overflow <= 1'b0;
    else if (br_fire && kind == BR_SPLIT && !fits) overflow <= 1'b1;
  end
endmodule

// File: rtl/simt_reconv_stack_chk.sv
module simt_reconv_stack_chk #(
  parameter int LANES = 4,
  parameter int PC_W  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             kernel_exit,
  input logic             launch,
  input logic [PC_W-1:0]  start_pc,
  input logic             br_valid,
  input logic             br_ready,
  input logic [LANES-1:0] br_taken,
  input logic [PC_W-1:0]  br_target,
  input logic             valid_pc,
  input logic [PC_W-1:0]  issue_pc,
  input logic [LANES-1:0] active_mask,
  input logic             stack_empty,
  input logic             overflow
);
  p_empty_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stack_empty |-> (!valid_pc && active_mask == '0));

  p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !kernel_exit) |=>
      (valid_pc && active_mask == '1 && issue_pc == $past(start_pc) && !overflow));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> ($stable(issue_pc) && $stable(active_mask)));

  p_uniform_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_ready && !kernel_exit && !launch &&
     ((br_taken & active_mask) == active_mask)) |=>
      (issue_pc == $past(br_target) && active_mask == $past(active_mask)));

  p_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    kernel_exit |=> (stack_empty && !valid_pc && !overflow));

  p_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_pc |-> !br_ready);
endmodule

bind simt_reconv_stack simt_reconv_stack_chk #(.LANES(LANES), .PC_W(PC_W)) u_chk (.*);

// File: tb/simt_reconv_stack_bench.sv
module simt_reconv_stack_bench;
  localparam int L  = 4;
  localparam int PW = 8;
  localparam int TD = 4;
  localparam time CLK_P = 4ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic kernel_exit = 0, launch = 0, br_valid = 0, step_valid = 0;
  logic [PW-1:0] start_pc = 0, br_target = 0, br_fallthru = 0, br_reconv = 0, step_pc = 0;
  logic [L-1:0] br_taken = 0;
  logic br_ready, valid_pc, stack_empty, overflow;
  logic [PW-1:0] issue_pc;
  logic [L-1:0] active_mask;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  simt_reconv_stack #(.LANES(L), .PC_W(PW), .DEPTH(TD)) u_simt_reconv_stack (.*);

  // reference stack
  int m_cnt = 0;
  bit m_ovf = 0;
  bit m_hr [TD];
  logic [PW-1:0] m_rc [TD];
  logic [PW-1:0] m_nx [TD];
  logic [L-1:0] m_mk [TD];

  function automatic bit m_pend();
    return m_cnt > 0 && m_hr[m_cnt-1] && m_nx[m_cnt-1] == m_rc[m_cnt-1];
  endfunction
  function automatic bit m_valid();
    return m_cnt > 0 && !m_pend();
  endfunction

  function automatic void m_step();
    logic [L-1:0] t, n;
    int top;
    top = m_cnt - 1;
    if (kernel_exit) begin
      m_cnt = 0; m_ovf = 0;
    end else if (launch) begin
      m_cnt = 1; m_ovf = 0;
      m_hr[0] = 0; m_rc[0] = 0; m_nx[0] = start_pc; m_mk[0] = '1;
    end else if (m_pend()) begin
      m_cnt = m_cnt - 1;
    end else if (m_valid() && br_valid) begin
      t = br_taken & m_mk[top];
      n = m_mk[top] & ~br_taken;
      if (t == 0) m_nx[top] = br_fallthru;
      else if (n == 0) m_nx[top] = br_target;
      else if (m_cnt + 2 > TD) m_ovf = 1;
      else begin
        m_nx[top] = br_reconv;
        m_hr[m_cnt] = 1; m_rc[m_cnt] = br_reconv; m_nx[m_cnt] = br_fallthru; m_mk[m_cnt] = n;
        m_hr[m_cnt+1] = 1; m_rc[m_cnt+1] = br_reconv; m_nx[m_cnt+1] = br_target; m_mk[m_cnt+1] = t;
        m_cnt = m_cnt + 2;
      end
    end else if (m_valid() && step_valid) begin
      m_nx[top] = step_pc;
    end
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare(string req);
    logic [PW-1:0] e_pc;
    logic [L-1:0] e_mk;
    e_pc = (m_cnt > 0) ? m_nx[m_cnt-1] : '0;
    e_mk = (m_cnt > 0) ? m_mk[m_cnt-1] : '0;
    check(req, {valid_pc, br_ready, stack_empty, overflow, active_mask, issue_pc},
          {m_valid(), m_valid(), m_cnt == 0, m_ovf, e_mk, e_pc});
  endtask

  task automatic idle();
    kernel_exit = 0; launch = 0; br_valid = 0; step_valid = 0;
  endtask

  task automatic tick(string req);
    m_step();
    @(negedge clk);
    idle();
    compare(req);
  endtask

  task automatic expect_issue(string req, logic [PW-1:0] pc, logic [L-1:0] mk);
    check(req, {valid_pc, active_mask, issue_pc}, {1'b1, mk, pc});
  endtask

  task automatic branch(logic [L-1:0] tk, logic [PW-1:0] tg, ft, rc);
    br_valid = 1; br_taken = tk; br_target = tg; br_fallthru = ft; br_reconv = rc;
  endtask

  task automatic step(logic [PW-1:0] pc);
    step_valid = 1; step_pc = pc;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare("R1 reset");
    check("R1 mask at reset", active_mask, '0);

    // R10: offers while empty are ignored
    branch(4'b1111, 8'd9, 8'd9, 8'd9); step(8'd7);
    tick("R10 ignored when empty");

    // R12 issue order, with R2/R4/R5/R7/R8
    launch = 1; start_pc = 8'd0; tick("R2 launch");
    expect_issue("R2 A/1111", 8'd0, 4'b1111);
    branch(4'b1111, 8'd1, 8'd5, 8'd5); tick("R4 uniform taken");
    expect_issue("R12 B/1111", 8'd1, 4'b1111);
    branch(4'b1001, 8'd2, 8'd3, 8'd4); tick("R5 split");
    expect_issue("R12 C/1001", 8'd2, 4'b1001);
    step(8'd4); tick("R7 reach reconv");
    check("R7 bubble", valid_pc, 1'b0);
    branch(4'b0000, 8'd9, 8'd9, 8'd9); tick("R10 branch in bubble");
    expect_issue("R12 D/0110", 8'd3, 4'b0110);
    step(8'd4); tick("R7 reach reconv");
    tick("R7 pop");
    expect_issue("R12 E/1111", 8'd4, 4'b1111);
    step(8'd6); tick("R6 step");
    expect_issue("R12 G/1111", 8'd6, 4'b1111);
    step(8'd6); tick("R8 bottom stays");
    check("R8 bottom valid", valid_pc, 1'b1);
    branch(4'b0000, 8'd20, 8'd21, 8'd30); step(8'd40); tick("R11 branch wins");
    expect_issue("R4 all not taken", 8'd21, 4'b1111);
    check("R11 step dropped", issue_pc, 8'd21);

    // R3 overflow at depth 4
    branch(4'b0011, 8'd10, 8'd11, 8'd12); tick("R5 split");
    branch(4'b0001, 8'd13, 8'd14, 8'd15); tick("R3 overflow");
    check("R3 overflow set", overflow, 1'b1);
    expect_issue("R3 stack unchanged", 8'd10, 4'b0011);
    step(8'd16); tick("R3 sticky");
    check("R3 overflow held", overflow, 1'b1);
    kernel_exit = 1; launch = 1; start_pc = 8'd50; tick("R9 exit over launch");
    check("R9 empty", stack_empty, 1'b1);
    check("R9 overflow cleared", overflow, 1'b0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom_range(99));
      if (r < 2) kernel_exit = 1;
      if (r < 6 || m_cnt == 0) begin launch = 1; start_pc = PW'($urandom_range(15)); end
      else begin
        if ($urandom_range(1)) branch(L'($urandom), PW'($urandom_range(15)),
                                      PW'($urandom_range(15)), PW'($urandom_range(15)));
        if ($urandom_range(1)) begin
          if (m_cnt > 0 && m_hr[m_cnt-1] && $urandom_range(9) < 4) step(m_rc[m_cnt-1]);
          else step(PW'($urandom_range(15)));
        end
      end
      tick("R5 random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule